// File: doc/BRIEF.md
# MSI Capability Register Slice with Vector-Gated Mask

This block holds the message-signalled-interrupt capability fields of one port: the requested vector count (capable field), the allocated vector count (enable field), a per-vector mask, and a test-access bit. An interrupt generator reads the field values and the mask straight from the outputs. Software reads the same state through a registered host read port.

Two write sources reach the slice. The first is a privileged loader path, such as a serial boot-memory or two-wire management loader. It can write every field. The second is the ordinary host configuration path. It can always write the enable field, the mask and the test-access bit. It can write the capable field only while the test-access bit is set.

The number of writable mask bits follows the capable field, not the enable field. With the capable field at its reset value, the low four mask bits take any value from 0x0 to 0xF, whatever number of vectors is allocated.

Top module: `msi_cap_regs`

## Requirements
- R1: After reset, the capable field is 010b, the enable field is 000b, the mask is all zero, the test-access bit is 0 and the host read data is 0.
- R2: Mask bit n accepts writes only when n < 2^capable. Every other mask bit reads 0 and ignores writes. At reset, mask bits 3:0 read back any written value from 0x0 to 0xF.
- R3: Offsets are as follows. Offset 0 holds the control word, with the capable field in bits 2:0 and the enable field in bits 6:4. Offset 1 holds the mask. Offset 2 holds the test-access bit in bit 0. Every other offset and every reserved bit reads 0. Read data appears on the clock after the read strobe and holds until the next strobe.
- R4: A write to offset 0 from either path sets the enable field. The written value is clamped to the capable value in force after the write. For example, 010b with a capable value of 2 or more allocates four vectors.
- R5: A host write to offset 0 changes the capable field only while the test-access bit is 1. A loader write always changes it.
- R6: A capable value above MAX_LOG is stored as MAX_LOG.
- R7: Lowering the capable field clears every mask bit at or above the new limit in the same cycle.
- R8: The test-access bit is written from bit 0 of a write to offset 2, from either path.
- R9: When both paths write in the same cycle, the loader write takes effect and the host write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hostWrEn | input | 1 | Host configuration write strobe |
| hostRdEn | input | 1 | Host read strobe |
| hostAddr | input | ADDR_W | Host word offset, used for reads and writes |
| hostWrData | input | DATA_W | Host write data |
| hostRdData | output | DATA_W | Registered read data |
| ldrWrEn | input | 1 | Loader write strobe |
| ldrAddr | input | ADDR_W | Loader word offset |
| ldrWrData | input | DATA_W | Loader write data |
| capField | output | 3 | Current capable field |
| enField | output | 3 | Current enable field |
| vecMask | output | 2^MAX_LOG | Per-vector mask for the interrupt generator |
| testAccess | output | 1 | Current test-access bit |

## Verification
The bench builds the slice with its default parameters: MAX_LOG of 5, a 32-bit data word and 4-bit offsets. With these values the capable field runs through every legal value from 0 to 5, and a write of 7 shows the clamp to 5. The full 32-bit mask can be opened and then narrowed back to one or two bits. The bench also covers the lock on the capable field, a same-cycle write from both paths, and reads of unused offsets.

// File: rtl/msi_cap_pkg.sv
package msi_cap_pkg;

  localparam int CAP_W = 3;

  localparam int OFF_CTL  = 0;
  localparam int OFF_MASK = 1;
  localparam int OFF_TEST = 2;

  localparam int CAP_LSB = 0;
  localparam int EN_LSB  = 4;

  typedef struct packed {
    logic wrEnable;
    logic wrCapable;
    logic wrMask;
    logic wrTest;
    logic rdStb;
  } regStb_t;

endpackage

// File: rtl/msi_cap_ctrl.sv
module msi_cap_ctrl
  import msi_cap_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hostWrEn,
  input  logic              hostRdEn,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWrData,
  input  logic              ldrWrEn,
  input  logic [ADDR_W-1:0] ldrAddr,
  input  logic [DATA_W-1:0] ldrWrData,
  input  logic              testAccess,
  output regStb_t           stb,
  output logic [DATA_W-1:0] selData
);

  logic              anyWr;
  logic [ADDR_W-1:0] selAddr;

  // R9: the loader wins a same-cycle collision
  assign anyWr   = ldrWrEn | hostWrEn;
  assign selAddr = ldrWrEn ? ldrAddr : hostAddr;
  assign selData = ldrWrEn ? ldrWrData : hostWrData;

  always_comb begin
    stb           = '0;
    stb.rdStb     = hostRdEn;
    stb.wrEnable  = anyWr && (selAddr == ADDR_W'(OFF_CTL));
    stb.wrCapable = stb.wrEnable && (ldrWrEn || testAccess);
    stb.wrMask    = anyWr && (selAddr == ADDR_W'(OFF_MASK));
    stb.wrTest    = anyWr && (selAddr == ADDR_W'(OFF_TEST));
  end

  // R5: a host write without test access never reaches the capable field
  a_r5_cap_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (hostWrEn && !ldrWrEn && !testAccess) |-> !stb.wrCapable);

endmodule

// File: rtl/msi_cap_dp.sv
module msi_cap_dp
  import msi_cap_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 32,
  parameter int MAX_LOG = 5,
  localparam int MASK_W = 1 << MAX_LOG
) (
  input  logic              clk,
  input  logic              rst_n,
  input  regStb_t           stb,
  input  logic [DATA_W-1:0] selData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [CAP_W-1:0]  capQ,
  output logic [CAP_W-1:0]  enQ,
  output logic [MASK_W-1:0] maskQ,
  output logic              testQ,
  output logic [DATA_W-1:0] rdDataQ
);

  localparam logic [CAP_W-1:0] MAX_CAP   = CAP_W'(MAX_LOG);
  localparam logic [CAP_W-1:0] RESET_CAP = 3'b010;

  logic [CAP_W-1:0]  capWr, capNext, enWr, enNext;
  logic [MASK_W-1:0] allowNext, allowNow, maskNext;
  logic [DATA_W-1:0] rdNext;

  // R6: clamp the capable value to the widest supported mask
  assign capWr   = selData[CAP_LSB +: CAP_W];
  assign capNext = stb.wrCapable ? ((capWr > MAX_CAP) ? MAX_CAP : capWr) : capQ;

  // R4: the enable value never exceeds the capable value
  assign enWr   = stb.wrEnable ? selData[EN_LSB +: CAP_W] : enQ;
  assign enNext = (enWr > capNext) ? capNext : enWr;

  // R2/R7: mask bits at or above 2^capable are forced to zero
  for (genvar n = 0; n < MASK_W; n++) begin : g_allow
    assign allowNext[n] = (n < (1 << capNext));
    assign allowNow[n]  = (n < (1 << capQ));
  end

  assign maskNext = (stb.wrMask ? selData[MASK_W-1:0] : maskQ) & allowNext;

  always_comb begin
    rdNext = '0;
    case (rdAddr)
      ADDR_W'(OFF_CTL): begin
        rdNext[CAP_LSB +: CAP_W] = capQ;
        rdNext[EN_LSB +: CAP_W]  = enQ;
      end
      ADDR_W'(OFF_MASK): rdNext[MASK_W-1:0] = maskQ;
      ADDR_W'(OFF_TEST): rdNext[0] = testQ;
      default: rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      capQ    <= RESET_CAP;
      enQ     <= '0;
      maskQ   <= '0;
      testQ   <= 1'b0;
      rdDataQ <= '0;
    end else begin
      capQ  <= capNext;
      enQ   <= enNext;
      maskQ <= maskNext;
      if (stb.wrTest) testQ <= selData[0];
      if (stb.rdStb) rdDataQ <= rdNext;
    end
  end

  // R2: no mask bit is set outside the limit of the capable field
  a_r2_mask_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (maskQ & ~allowNow) == '0);

  // R4: the stored enable value never exceeds the capable value
  a_r4_en_le_cap: assert property (@(posedge clk) disable iff (!rst_n)
    enQ <= capQ);

  // R6: the capable field stays within the supported range
  a_r6_cap_range: assert property (@(posedge clk) disable iff (!rst_n)
    capQ <= MAX_CAP);

  // R5: the capable field moves only on a permitted write
  a_r5_cap_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !stb.wrCapable |=> $stable(capQ));

  // R3: read data holds between read strobes
  a_r3_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !stb.rdStb |=> $stable(rdDataQ));

endmodule

// File: rtl/msi_cap_regs.sv
module msi_cap_regs
  import msi_cap_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 32,
  parameter int MAX_LOG = 5,
  localparam int MASK_W = 1 << MAX_LOG
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hostWrEn,
  input  logic              hostRdEn,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWrData,
  output logic [DATA_W-1:0] hostRdData,
  input  logic              ldrWrEn,
  input  logic [ADDR_W-1:0] ldrAddr,
  input  logic [DATA_W-1:0] ldrWrData,
  output logic [2:0]        capField,
  output logic [2:0]        enField,
  output logic [MASK_W-1:0] vecMask,
  output logic              testAccess
);

  regStb_t           stb;
  logic [DATA_W-1:0] selData;

  initial begin
    assert (MASK_W <= DATA_W && MAX_LOG <= 7)
      else $error("msi_cap_regs: mask wider than the data word");
  end

  msi_cap_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .hostWrEn   (hostWrEn),
    .hostRdEn   (hostRdEn),
    .hostAddr   (hostAddr),
    .hostWrData (hostWrData),
    .ldrWrEn    (ldrWrEn),
    .ldrAddr    (ldrAddr),
    .ldrWrData  (ldrWrData),
    .testAccess (testAccess),
    .stb        (stb),
    .selData    (selData)
  );

  msi_cap_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAX_LOG(MAX_LOG)) i_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .stb     (stb),
    .selData (selData),
    .rdAddr  (hostAddr),
    .capQ    (capField),
    .enQ     (enField),
    .maskQ   (vecMask),
    .testQ   (testAccess),
    .rdDataQ (hostRdData)
  );

endmodule

// File: tb/test_msi_cap_regs.sv
module test_msi_cap_regs;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 32;
  localparam int MAX_LOG = 5;
  localparam int MASK_W = 1 << MAX_LOG;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hostWrEn = 1'b0, hostRdEn = 1'b0, ldrWrEn = 1'b0;
  logic [ADDR_W-1:0] hostAddr = '0, ldrAddr = '0;
  logic [DATA_W-1:0] hostWrData = '0, ldrWrData = '0, hostRdData;
  logic [2:0] capField, enField;
  logic [MASK_W-1:0] vecMask;
  logic testAccess;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  typedef struct {
    logic [DATA_W-1:0] exp;
    string tag;
  } rdItem_t;
  rdItem_t rdQ[$];
  logic rdLat = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  msi_cap_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAX_LOG(MAX_LOG)) i_msi_cap_regs (
    .clk(clk), .rst_n(rst_n),
    .hostWrEn(hostWrEn), .hostRdEn(hostRdEn), .hostAddr(hostAddr),
    .hostWrData(hostWrData), .hostRdData(hostRdData),
    .ldrWrEn(ldrWrEn), .ldrAddr(ldrAddr), .ldrWrData(ldrWrData),
    .capField(capField), .enField(enField), .vecMask(vecMask),
    .testAccess(testAccess)
  );

  task automatic check(string tag, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // monitor: a read strobe seen at an edge is compared at the next falling edge
  always @(posedge clk) rdLat <= hostRdEn;
  always @(negedge clk) begin
    if (rdLat) begin
      if (rdQ.size() == 0) begin
        check("R3 unexpected read", 1, 0);
      end else begin
        rdItem_t it;
        it = rdQ.pop_front();
        check(it.tag, hostRdData, it.exp);
      end
    end
  end

  task automatic hostWr(int addr, logic [DATA_W-1:0] d);
    @(negedge clk);
    hostWrEn = 1; hostAddr = ADDR_W'(addr); hostWrData = d;
    @(negedge clk);
    hostWrEn = 0;
  endtask

  task automatic ldrWr(int addr, logic [DATA_W-1:0] d);
    @(negedge clk);
    ldrWrEn = 1; ldrAddr = ADDR_W'(addr); ldrWrData = d;
    @(negedge clk);
    ldrWrEn = 0;
  endtask

  task automatic rd(int addr, logic [DATA_W-1:0] exp, string tag);
    rdItem_t it;
    @(negedge clk);
    it.exp = exp; it.tag = tag;
    rdQ.push_back(it);
    hostRdEn = 1; hostAddr = ADDR_W'(addr);
    @(negedge clk);
    hostRdEn = 0;
  endtask

  task automatic outs(string tag, int cap, int en, logic [MASK_W-1:0] m, bit t);
    check({tag, " cap"}, DATA_W'(capField), DATA_W'(cap));
    check({tag, " en"}, DATA_W'(enField), DATA_W'(en));
    check({tag, " mask"}, DATA_W'(vecMask), DATA_W'(m));
    check({tag, " test"}, DATA_W'(testAccess), DATA_W'(t));
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    outs("R1 reset", 2, 0, '0, 0);
    check("R1 rdData", hostRdData, '0);
    rst_n = 1;
    @(negedge clk);

    // R2: four mask bits accept every value 0..F at the reset capable value
    for (int v = 0; v < 16; v++) begin
      hostWr(1, DATA_W'(v));
      rd(1, DATA_W'(v), "R2 mask readback");
    end
    hostWr(1, '1);
    check("R2 upper mask ignored", DATA_W'(vecMask), 32'hF);

    // R4/R5: host writes 4 vectors, and its capable write of 7 is ignored
    hostWr(0, 32'h27);
    outs("R5 host cap locked", 2, 2, 4'hF, 0);
    rd(0, 32'h22, "R3 ctl layout");
    hostWr(0, 32'h72);
    check("R4 en clamped", DATA_W'(enField), 2);

    // R5/R6: the loader reaches capable, with clamping above MAX_LOG
    ldrWr(0, 32'h35);
    outs("R5 loader cap", 5, 3, 4'hF, 0);
    hostWr(1, '1);
    check("R2 full mask at cap5", DATA_W'(vecMask), 32'hFFFF_FFFF);
    ldrWr(0, 32'h77);
    check("R6 cap clamp", DATA_W'(capField), 5);
    check("R6 en clamp", DATA_W'(enField), 5);

    // R7: lowering capable trims the mask
    ldrWr(0, 32'h31);
    outs("R7 cap1", 1, 1, 32'h3, 0);
    ldrWr(0, 32'h10);
    outs("R7 cap0", 0, 0, 32'h1, 0);
    hostWr(1, 32'hE);
    check("R2 cap0 ignores high bits", DATA_W'(vecMask), 0);

    // R8: test-access bit from both paths; R5 unlocks capable for the host
    hostWr(2, 32'h1);
    check("R8 host sets test", DATA_W'(testAccess), 1);
    rd(2, 32'h1, "R8 test readback");
    hostWr(0, 32'h23);
    outs("R5 host cap with test", 3, 2, '0, 1);
    hostWr(2, 32'h0);
    check("R8 host clears test", DATA_W'(testAccess), 0);
    ldrWr(2, 32'h1);
    check("R8 loader sets test", DATA_W'(testAccess), 1);
    ldrWr(2, 32'h0);
    check("R8 loader clears test", DATA_W'(testAccess), 0);

    // R9: same-cycle collision, the loader wins
    @(negedge clk);
    ldrWrEn = 1; ldrAddr = 0; ldrWrData = 32'h44;
    hostWrEn = 1; hostAddr = 0; hostWrData = 32'h11;
    @(negedge clk);
    ldrWrEn = 0; hostWrEn = 0;
    check("R9 loader wins cap", DATA_W'(capField), 4);
    check("R9 loader wins en", DATA_W'(enField), 4);

    // R3: unused offsets, and hold between read strobes
    rd(3, '0, "R3 unused offset");
    rd(0, 32'h44, "R3 ctl read");
    hostWr(1, 32'h5);
    check("R3 read data held", hostRdData, 32'h44);
    rd(1, 32'h5, "R3 mask read");

    repeat (3) @(negedge clk);
    check("R3 queue drained", DATA_W'(rdQ.size()), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule